// File: doc/BRIEF.md
# I2C Master Register Sequencer

This block is the software-facing front end of an I2C master. Five byte-wide registers sit on a simple single-cycle read/write bus. Register accesses have side effects, and these side effects start byte-level bus operations. There are four operations: start with address, send one byte, receive one byte and stop. Each one goes to a separate byte engine over a request/done handshake. The engine does the SCL/SDA timing and reports ACK or NACK for each operation.

The sequencer keeps three status bits: busy, last-bit (NACK seen) and interrupt-pending. It also keeps a hidden line-free flag, which gates the automatic next transfer, and it drives one level-sensitive interrupt. The usual software loop is:
- write the data byte;
- clear pending, which launches the send;
- wait for the interrupt.

In receive mode, a read of the data register fetches the byte and also starts the next receive. The line-timing register is storage only, and slave-mode operation is out of scope.

Top module: `i2cseq_top`

## Requirements
- R1: After reset, the control, status and line-timing registers read 0x00, the data and own-address registers read 0xFF, no request is active, the interrupt is low and the line is free.
- R2: Registers sit at offsets 0x00 control, 0x04 status, 0x08 own address, 0x0C data and 0x10 line timing. A read of any other offset returns 0, and a write to any other offset changes nothing. Read data shows the register contents as they were before the clock edge that ends the access.
- R3: Control bits are 7 ACK-check enable, 5 interrupt enable and 4 pending. A control write stores bits 7:5 and 3:0, and a control write can never set pending.
- R4: A control write with bit 4 = 0 while pending is set does the following, in order:
  - it clears pending and lowers the interrupt;
  - if interrupts are now disabled, busy clears;
  - if busy remains and the line is free, it launches a send (mode 3) or a receive (mode 2);
  - if busy remains and the line is not free, pending and the interrupt are raised again.
- R5: Status bits are 7:6 mode (2 = master receive, 3 = master transmit, bit 7 = 0 slave), 5 busy, 4 output enable and 0 last-bit. A status write keeps busy and takes every other bit from the written value. If the written value has output enable 0, busy clears, the line becomes free and the interrupt lowers.
- R6: In master mode with output enabled, a status write with bit 5 = 1 clears last-bit, sets busy, marks the line not free and requests a start carrying the data register. On completion:
  - a NACK with ACK checking on sets last-bit and raises the interrupt;
  - otherwise, in receive mode, a receive is launched at once;
  - otherwise the interrupt is raised.
- R7: In master mode with output enabled, a status write with bit 5 = 0 requests a stop and frees the line, and busy clears only if pending is clear. In slave mode a status write only stores bits.
- R8: The own-address register takes writes only while output is disabled, and the data register only while output is enabled. An accepted data write frees the line. It launches a send when the mode is 3, busy is set and pending is clear.
- R9: A data read frees the line. It launches a receive when the mode is 2, busy is set and pending is clear.
- R10: Every send or receive launch clears last-bit and marks the line not free. On send or receive completion:
  - a NACK with ACK checking on sets last-bit;
  - a successful receive loads the engine byte into the data register;
  - pending and the interrupt are set only when interrupts are enabled.
- R11: The engine request is held, with stable operation code (0 start, 1 send, 2 receive, 3 stop) and byte, until the done pulse. Only one operation is outstanding at a time, and a trigger that arrives while the engine is occupied updates the registers but requests nothing. The byte is the data register for start and send, and 0 for receive and stop.
- R12: When a completion and a register access fall in the same cycle, the completion takes effect first and the access sees its result. A receive chained from a start wins the engine over any launch the access would make.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during a read strobe |
| irq | output | 1 | Level interrupt |
| eng_req | output | 1 | Operation request to the byte engine |
| eng_op | output | 2 | Operation code |
| eng_wbyte | output | 8 | Address or data byte for the engine |
| eng_done | input | 1 | One-cycle completion pulse |
| eng_nack | input | 1 | Completion was not acknowledged |
| eng_rbyte | input | 8 | Received byte |

## Verification
An engine completion and a software register access can land in the same cycle. For example, a data read can arrive just as a receive finishes, or a control write can arrive just as a start completes and chains a receive. A long random phase with varying engine latency, random NACKs and dense register traffic provokes these overlaps, and the bench counts them and requires that some occurred. A behavioural model that applies the completion before the access judges each overlap cycle by cycle, comparing the request, operation, byte, interrupt and every read value.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
    localparam int NREG    = 5;
    localparam int RG_CON  = 0;
    localparam int RG_STAT = 1;
    localparam int RG_OADR = 2;
    localparam int RG_DATA = 3;
    localparam int RG_LC   = 4;

    localparam int CON_ACK  = 7;
    localparam int CON_IEN  = 5;
    localparam int CON_PEND = 4;

    localparam int ST_BUSY = 5;
    localparam int ST_OE   = 4;
    localparam int ST_LAST = 0;

    localparam logic [1:0] MODE_MRX = 2'd2;
    localparam logic [1:0] MODE_MTX = 2'd3;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_STOP  = 2'd3
    } op_e;

    typedef struct packed {
        logic [7:0] con;
        logic [7:0] stat;
        logic [7:0] data;
        logic [7:0] oadr;
        logic [7:0] lc;
        logic       free;
        logic       irq;
    } regs_t;

    function automatic int reg_offset(input int idx);
        return idx * 4;
    endfunction
endpackage

// File: rtl/i2cseq_decode.sv
module i2cseq_decode
    import i2cseq_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NREG-1:0]   hit
);
    for (genvar gi = 0; gi < NREG; gi++) begin : g_hit
        assign hit[gi] = bus_sel && (bus_addr == ADDR_W'(reg_offset(gi)));
    end
endmodule

// File: rtl/i2cseq_req.sv
module i2cseq_req
    import i2cseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch,
    input  op_e        launch_op,
    input  logic [7:0] launch_byte,
    input  logic       done,
    output logic       req,
    output logic [1:0] op,
    output logic [7:0] wbyte
);
    logic       req_d, req_q;
    logic [1:0] op_d, op_q;
    logic [7:0] byte_d, byte_q;

    always_comb begin
        req_d  = req_q;
        op_d   = op_q;
        byte_d = byte_q;
        if (launch) begin
            req_d  = 1'b1;
            op_d   = launch_op;
            byte_d = launch_byte;
        end else if (done) begin
            req_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            op_q   <= 2'd0;
            byte_q <= 8'd0;
        end else begin
            req_q  <= req_d;
            op_q   <= op_d;
            byte_q <= byte_d;
        end
    end

    assign req   = req_q;
    assign op    = op_q;
    assign wbyte = byte_q;
endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top
    import i2cseq_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq,
    output logic              eng_req,
    output logic [1:0]        eng_op,
    output logic [7:0]        eng_wbyte,
    input  logic              eng_done,
    input  logic              eng_nack,
    input  logic [7:0]        eng_rbyte
);
    regs_t           q, n;
    logic [NREG-1:0] hit;
    logic            launch;
    op_e             l_op;
    logic [7:0]      l_byte;
    logic            chain_go, acc_go;
    op_e             acc_op;
    logic            wr_en, rd_en, fin;
    logic [NREG-1:0][7:0] view;
    logic [7:0]      rd_mux;
    logic [7:0]      con_v, stat_v, data_v, oadr_v;

    i2cseq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel (bus_sel),
        .bus_addr(bus_addr),
        .hit     (hit)
    );

    i2cseq_req u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .launch_op  (l_op),
        .launch_byte(l_byte),
        .done       (eng_done),
        .req        (eng_req),
        .op         (eng_op),
        .wbyte      (eng_wbyte)
    );

    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;
    assign fin   = eng_req && eng_done;

    always_comb begin
        n        = q;
        chain_go = 1'b0;
        acc_go   = 1'b0;
        acc_op   = OP_STOP;
        // completion first (R12)
        if (fin) begin
            if (eng_op == OP_START) begin
                if (eng_nack && n.con[CON_ACK]) begin
                    n.stat[ST_LAST] = 1'b1;
                    if (n.con[CON_IEN]) begin
                        n.con[CON_PEND] = 1'b1;
                        n.irq = 1'b1;
                    end
                end else if (n.stat[7:6] == MODE_MRX) begin
                    n.stat[ST_LAST] = 1'b0;
                    n.free   = 1'b0;
                    chain_go = 1'b1;
                end else if (n.con[CON_IEN]) begin
                    n.con[CON_PEND] = 1'b1;
                    n.irq = 1'b1;
                end
            end else if (eng_op != OP_STOP) begin
                if (eng_nack && n.con[CON_ACK]) begin
                    n.stat[ST_LAST] = 1'b1;
                end else if (eng_op == OP_RECV) begin
                    n.data = eng_rbyte;
                end
                if (n.con[CON_IEN]) begin
                    n.con[CON_PEND] = 1'b1;
                    n.irq = 1'b1;
                end
            end
        end
        // register access second
        if (wr_en && hit[RG_CON]) begin
            n.con = {bus_wdata[7:5], q.con[CON_PEND] | n.con[CON_PEND], bus_wdata[3:0]};
            if (n.con[CON_PEND] && !bus_wdata[CON_PEND]) begin
                n.con[CON_PEND] = 1'b0;
                n.irq = 1'b0;
                if (!n.con[CON_IEN]) n.stat[ST_BUSY] = 1'b0;
                if (n.stat[ST_BUSY]) begin
                    if (n.free) begin
                        if (n.stat[7:6] == MODE_MTX || n.stat[7:6] == MODE_MRX) begin
                            n.stat[ST_LAST] = 1'b0;
                            n.free = 1'b0;
                            acc_go = 1'b1;
                            acc_op = (n.stat[7:6] == MODE_MTX) ? OP_SEND : OP_RECV;
                        end
                    end else begin
                        n.con[CON_PEND] = 1'b1;
                        n.irq = 1'b1;
                    end
                end
            end
        end
        if (wr_en && hit[RG_STAT]) begin
            n.stat = {bus_wdata[7:6], n.stat[ST_BUSY], bus_wdata[4:0]};
            if (!bus_wdata[ST_OE]) begin
                n.stat[ST_BUSY] = 1'b0;
                n.free = 1'b1;
                n.irq  = 1'b0;
            end else if (bus_wdata[7]) begin
                if (bus_wdata[ST_BUSY]) begin
                    n.stat[ST_LAST] = 1'b0;
                    n.stat[ST_BUSY] = 1'b1;
                    n.free = 1'b0;
                    acc_go = 1'b1;
                    acc_op = OP_START;
                end else begin
                    acc_go = 1'b1;
                    acc_op = OP_STOP;
                    if (!n.con[CON_PEND]) n.stat[ST_BUSY] = 1'b0;
                    n.free = 1'b1;
                end
            end
        end
        if (wr_en && hit[RG_OADR] && !n.stat[ST_OE]) n.oadr = bus_wdata;
        if (wr_en && hit[RG_DATA] && n.stat[ST_OE]) begin
            n.data = bus_wdata;
            n.free = 1'b1;
            if (n.stat[7:6] == MODE_MTX && n.stat[ST_BUSY] && !n.con[CON_PEND]) begin
                n.stat[ST_LAST] = 1'b0;
                n.free = 1'b0;
                acc_go = 1'b1;
                acc_op = OP_SEND;
            end
        end
        if (wr_en && hit[RG_LC]) n.lc = bus_wdata;
        if (rd_en && hit[RG_DATA]) begin
            n.free = 1'b1;
            if (n.stat[7:6] == MODE_MRX && n.stat[ST_BUSY] && !n.con[CON_PEND]) begin
                n.stat[ST_LAST] = 1'b0;
                n.free = 1'b0;
                acc_go = 1'b1;
                acc_op = OP_RECV;
            end
        end
        // engine arbitration: chained receive first, then access, only if free (R11)
        launch = 1'b0;
        l_op   = OP_STOP;
        if (chain_go) begin
            launch = 1'b1;
            l_op   = OP_RECV;
        end else if (acc_go && (!eng_req || eng_done)) begin
            launch = 1'b1;
            l_op   = acc_op;
        end
        l_byte = (l_op == OP_START || l_op == OP_SEND) ? n.data : 8'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.con  <= 8'h00;
            q.stat <= 8'h00;
            q.data <= 8'hFF;
            q.oadr <= 8'hFF;
            q.lc   <= 8'h00;
            q.free <= 1'b1;
            q.irq  <= 1'b0;
        end else begin
            q <= n;
        end
    end

    assign view[RG_CON]  = q.con;
    assign view[RG_STAT] = q.stat;
    assign view[RG_OADR] = q.oadr;
    assign view[RG_DATA] = q.data;
    assign view[RG_LC]   = q.lc;

    always_comb begin
        rd_mux = 8'd0;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) rd_mux = rd_mux | view[i];
        end
    end

    assign bus_rdata = rd_en ? rd_mux : 8'd0;
    assign irq       = q.irq;
    assign con_v     = q.con;
    assign stat_v    = q.stat;
    assign data_v    = q.data;
    assign oadr_v    = q.oadr;
endmodule

// File: rtl/i2cseq_chk.sv
module i2cseq_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              irq,
    input logic              eng_req,
    input logic              eng_done,
    input logic [1:0]        eng_op,
    input logic [7:0]        eng_wbyte,
    input logic [7:0]        con,
    input logic [7:0]        stat,
    input logic [7:0]        data,
    input logic [7:0]        oadr
);
    logic w_con, w_stat, w_oadr, w_data, fin;
    assign w_con  = bus_sel && bus_wr && bus_addr == ADDR_W'(0);
    assign w_stat = bus_sel && bus_wr && bus_addr == ADDR_W'(4);
    assign w_oadr = bus_sel && bus_wr && bus_addr == ADDR_W'(8);
    assign w_data = bus_sel && bus_wr && bus_addr == ADDR_W'(12);
    assign fin    = eng_req && eng_done;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && !eng_done |=> eng_req && $stable(eng_op) && $stable(eng_wbyte)); // R11
    AST_IRQ_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> con[4]); // R10
    AST_NO_SW_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        w_con && !con[4] && !fin |=> !con[4]); // R3
    AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        w_stat && !bus_wdata[4] |=> !irq && !stat[5]); // R5
    AST_DATA_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        w_data && !stat[4] && !fin |=> $stable(data)); // R8
    AST_OADR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        w_oadr && stat[4] |=> $stable(oadr)); // R8
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        w_stat && bus_wdata[7] && bus_wdata[5] && bus_wdata[4] |=> stat[5]); // R6
endmodule

bind i2cseq_top i2cseq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .irq      (irq),
    .eng_req  (eng_req),
    .eng_done (eng_done),
    .eng_op   (eng_op),
    .eng_wbyte(eng_wbyte),
    .con      (con_v),
    .stat     (stat_v),
    .data     (data_v),
    .oadr     (oadr_v)
);

// File: tb/sim_i2cseq_top.sv
module sim_i2cseq_top;
    localparam int CLK_P = 10;
    localparam int AW = 5;

    logic clk = 0, rst_n = 0;
    logic bus_sel = 0, bus_wr = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic irq, eng_req;
    logic [1:0] eng_op;
    logic [7:0] eng_wbyte;
    logic eng_done = 0, eng_nack = 0;
    logic [7:0] eng_rbyte = '0;

    int total = 0, bad = 0, coll = 0;
    int lat = 3, cnt = 0;
    bit nack_cfg = 0, rnd_eng = 0, finished = 0;
    logic [7:0] rb_cfg = 8'h00;

    always #(CLK_P/2) clk = ~clk;

    i2cseq_top #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .eng_req(eng_req), .eng_op(eng_op), .eng_wbyte(eng_wbyte),
        .eng_done(eng_done), .eng_nack(eng_nack), .eng_rbyte(eng_rbyte)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // byte engine responder
    always @(negedge clk) begin
        if (eng_done) begin
            eng_done <= 0;
            cnt = 0;
        end else if (eng_req) begin
            cnt++;
            if (cnt >= lat) begin
                eng_done  <= 1;
                eng_nack  <= rnd_eng ? ($urandom_range(0, 3) == 0) : nack_cfg;
                eng_rbyte <= rnd_eng ? 8'($urandom) : rb_cfg;
                if (rnd_eng) lat = $urandom_range(1, 5);
            end
        end
    end

    // behavioural reference model
    logic [7:0] m_con, m_stat, m_data, m_oadr, m_lc, m_byte;
    logic [1:0] m_op;
    bit m_free, m_irq, m_act, m_ef;

    function automatic logic [7:0] mread(logic [AW-1:0] a);
        case (a)
            5'd0:  return m_con;
            5'd4:  return m_stat;
            5'd8:  return m_oadr;
            5'd12: return m_data;
            5'd16: return m_lc;
            default: return 8'h00;
        endcase
    endfunction

    task automatic mlaunch(logic [1:0] op);
        if (m_ef) begin
            m_act = 1; m_op = op; m_ef = 0;
            m_byte = (op == 0 || op == 1) ? m_data : 8'h00;
        end
    endtask

    task automatic mxfer(logic [1:0] op);
        m_stat[0] = 0; m_free = 0; mlaunch(op);
    endtask

    task automatic mraise();
        if (m_con[5]) begin m_con[4] = 1; m_irq = 1; end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_con = 0; m_stat = 0; m_data = 8'hFF; m_oadr = 8'hFF; m_lc = 0;
            m_free = 1; m_irq = 0; m_act = 0; m_op = 0; m_byte = 0;
        end else begin
            bit dn;
            logic [7:0] v;
            dn = m_act && eng_done;
            m_ef = !m_act || dn;
            if (dn && bus_sel) coll++;
            if (dn) begin
                m_act = 0;
                if (m_op == 0) begin
                    if (eng_nack && m_con[7]) begin m_stat[0] = 1; mraise(); end
                    else if (m_stat[7:6] == 2) mxfer(2);
                    else mraise();
                end else if (m_op != 3) begin
                    if (eng_nack && m_con[7]) m_stat[0] = 1;
                    else if (m_op == 2) m_data = eng_rbyte;
                    mraise();
                end
            end
            v = bus_wdata;
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    5'd0: begin
                        bit p;
                        p = m_con[4];
                        m_con = {v[7:5], p, v[3:0]};
                        if (p && !v[4]) begin
                            m_con[4] = 0; m_irq = 0;
                            if (!m_con[5]) m_stat[5] = 0;
                            if (m_stat[5]) begin
                                if (m_free) begin
                                    if (m_stat[7:6] == 3) mxfer(1);
                                    else if (m_stat[7:6] == 2) mxfer(2);
                                end else begin
                                    m_con[4] = 1; m_irq = 1;
                                end
                            end
                        end
                    end
                    5'd4: begin
                        m_stat = {v[7:6], m_stat[5], v[4:0]};
                        if (!v[4]) begin m_stat[5] = 0; m_free = 1; m_irq = 0; end
                        else if (v[7]) begin
                            if (v[5]) begin
                                m_stat[0] = 0; m_stat[5] = 1; m_free = 0; mlaunch(0);
                            end else begin
                                mlaunch(3);
                                if (!m_con[4]) m_stat[5] = 0;
                                m_free = 1;
                            end
                        end
                    end
                    5'd8:  if (!m_stat[4]) m_oadr = v;
                    5'd12: if (m_stat[4]) begin
                        m_data = v; m_free = 1;
                        if (m_stat[7:6] == 3 && m_stat[5] && !m_con[4]) mxfer(1);
                    end
                    5'd16: m_lc = v;
                    default: ;
                endcase
            end else if (bus_sel && bus_addr == 5'd12) begin
                m_free = 1;
                if (m_stat[7:6] == 2 && m_stat[5] && !m_con[4]) mxfer(2);
            end
        end
    end

    // cycle compare against the model (R12 covers overlap cycles)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            total++;
            if (eng_req !== m_act || irq !== m_irq ||
                (m_act && (eng_op !== m_op || eng_wbyte !== m_byte))) begin
                bad++;
                $display("FAIL R12 model req/op/byte/irq actual=%b/%0d/%h/%b expected=%b/%0d/%h/%b at %0t",
                         eng_req, eng_op, eng_wbyte, irq, m_act, m_op, m_byte, m_irq, $time);
            end
        end
    end

    task automatic wr(logic [AW-1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        d = bus_rdata;
        chk("R2 read vs model", d, mread(a));
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 60 && !irq; i++) @(posedge clk);
        #1;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 60 && eng_req; i++) @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1
        chk("R1 irq", irq, 0); chk("R1 req", eng_req, 0);
        rd(0, d);  chk("R1 control", d, 8'h00);
        rd(4, d);  chk("R1 status", d, 8'h00);
        rd(8, d);  chk("R1 own address", d, 8'hFF);
        rd(12, d); chk("R1 data", d, 8'hFF);
        rd(16, d); chk("R1 line timing", d, 8'h00);
        // R2
        wr(20, 8'h77); rd(20, d); chk("R2 out-of-map read", d, 0);
        rd(2, d); chk("R2 unaligned read", d, 0);
        rd(16, d); chk("R2 ignored write", d, 8'h00);
        wr(16, 8'h3C); rd(16, d); chk("R2 line timing store", d, 8'h3C);
        // R8 locks with output disabled
        wr(8, 8'h5A); rd(8, d); chk("R8 own address written", d, 8'h5A);
        wr(12, 8'h33); rd(12, d); chk("R8 data locked", d, 8'hFF);
        // R3
        wr(0, 8'hB0); rd(0, d); chk("R3 pend not settable", d, 8'hA0);
        chk("R3 irq low", irq, 0);
        wr(4, 8'hD0);
        wr(8, 8'h11); rd(8, d); chk("R8 own address locked", d, 8'h5A);
        wr(12, 8'hA4); chk("R8 no send while idle", eng_req, 0);
        // R6 start in transmit mode
        wr(4, 8'hF0);
        chk("R6 start req", eng_req, 1); chk("R6 start op", eng_op, 0);
        chk("R6 start byte", eng_wbyte, 8'hA4);
        rd(4, d); chk("R6 busy set", d, 8'hF0);
        wait_irq(); chk("R6 irq after start", irq, 1);
        rd(0, d); chk("R6 pending", d, 8'hB0);
        // R4 resume by clearing pending
        wr(12, 8'h5C); chk("R8 no send while pending", eng_req, 0);
        wr(0, 8'hA0);
        chk("R4 irq lowered", irq, 0); chk("R4 send op", eng_op, 1);
        chk("R4 send byte", eng_wbyte, 8'h5C);
        wait_irq();
        // R10 NACK
        nack_cfg = 1;
        wr(12, 8'h01); wr(0, 8'hA0); wait_idle(); wait_irq();
        rd(4, d); chk("R10 last-bit on NACK", d, 8'hF1);
        nack_cfg = 0;
        // R4 line not free -> re-raise
        wr(0, 8'hA0);
        chk("R4 re-raise", irq, 1); chk("R4 no request", eng_req, 0);
        // R4 interrupts disabled -> busy clears
        wr(0, 8'h80); rd(4, d); chk("R4 busy cleared", d, 8'hD1);
        // R7 stop
        wr(4, 8'hD0);
        chk("R7 stop req", eng_req, 1); chk("R7 stop op", eng_op, 3);
        wait_idle();
        // R5 output disable
        wr(4, 8'h00); rd(4, d); chk("R5 status cleared", d, 8'h00);
        chk("R5 irq low", irq, 0);
        // R9 receive mode
        rb_cfg = 8'h6E;
        wr(4, 8'h90); wr(12, 8'h51); wr(0, 8'hA0);
        wr(4, 8'hB0); chk("R6 start byte rx", eng_wbyte, 8'h51);
        wait_irq();
        rd(12, d); chk("R10 received byte", d, 8'h6E);
        chk("R9 no receive while pending", eng_req, 0);
        rb_cfg = 8'h3C;
        wr(0, 8'hA0); chk("R9 receive op", eng_op, 2); chk("R9 receive req", eng_req, 1);
        wait_irq(); rd(12, d); chk("R9 next byte", d, 8'h3C);
        rd(12, d); chk("R11 no launch while pending", eng_req, 0);
        // R10 interrupts disabled
        wr(0, 8'h80); rb_cfg = 8'h77;
        wr(4, 8'hB0); wait_idle(); wait_idle();
        chk("R10 no irq when disabled", irq, 0);
        rd(0, d); chk("R10 no pend when disabled", d, 8'h80);
        rd(12, d); chk("R10 byte loaded", d, 8'h77);
        wait_idle();
        wr(4, 8'h90); wait_idle(); wr(4, 8'h00);
        // R12 random overlap phase
        rnd_eng = 1;
        for (int k = 0; k < 6000; k++) begin
            @(negedge clk);
            if ($urandom_range(0, 9) < 4) begin
                int r;
                logic [AW-1:0] a;
                r = $urandom_range(0, 11);
                a = (r < 6) ? AW'(r * 4) : ((r < 8) ? AW'(12) : ((r < 10) ? AW'(0) : AW'(4)));
                bus_sel = 1;
                bus_wr  = $urandom_range(0, 2) != 0;
                bus_addr = a;
                bus_wdata = 8'($urandom);
                if (a == AW'(4)) bus_wdata[4] = ($urandom_range(0, 7) != 0);
                if (a == AW'(4)) bus_wdata[7] = ($urandom_range(0, 5) != 0);
                if (a == AW'(0)) bus_wdata[4] = 0;
                if (!bus_wr) begin
                    #1 chk("R12 random read", bus_rdata, mread(a));
                end
            end else begin
                bus_sel = 0;
            end
        end
        @(negedge clk); bus_sel = 0;
        chk("R12 overlaps seen", coll > 0, 1);
        repeat (3) @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule